// File: doc/BRIEF.md
# SPI Self-Test Loopback and Fault Injector

This block sits between a serial shift engine and its pads. It gives the engine self-test paths and ways to inject faults on purpose. Software writes one 32-bit control word. A 4-bit arming key must hold the exact value 0xA before any test path becomes active. When the block is armed, the control word selects one of three return paths for the engine's serial output:

- an internal (digital) return;
- a pad-level (analog) return that reads back the transmit pad;
- a pad-level (analog) return where the block drives the data onto the receive pad and reads it back there.

In analog mode the block can invert one chosen chip-select line. While armed, it can also force the engine's handshake input inactive (high) from the start of shifting to the end of the transfer. The engine's own error detection then reports a data-length error. When the block is not armed, every signal passes straight through with no register on the path.

The serial data lines are single-bit levels. They are not packetised, so there is no valid/ready handshake and no back-pressure anywhere. The register bus is a plain write strobe with write data. Read data always shows the stored word, with no wait cycles.

Top module: `spi_selftest_ctl`

## Requirements
- R1: After reset the control word reads 0. A write stores only the defined fields: arming key in bits 3:0, mode bit 4, return-path bit 5, chip-select fault enable bit 6, fault target in bits 10:8, length-fault bit 12. All other bits read 0 whatever was written. The written value is visible on the read port in the cycle after the write strobe.
- R2: Test mode is on only while bits 3:0 equal 4'hA. Every other key value leaves all paths in pass-through.
- R3: With test mode off, eng_rx equals pad_rx_in, pad_tx_out equals eng_tx, pad_cs_out equals eng_cs_num, eng_ena_in equals pad_ena_in, eng_cs_in equals pad_cs_in and pad_rx_oe is 0. All of these are combinational.
- R4: Digital loopback (key 0xA, bit 4 = 0): eng_rx follows eng_tx regardless of the pads.
- R5: Analog loopback through the transmit pad (bit 4 = 1, bit 5 = 0): eng_rx follows pad_tx_in and pad_rx_oe is 0.
- R6: Analog loopback through the receive pad (bit 4 = 1, bit 5 = 1): pad_rx_oe is 1, pad_rx_out follows eng_tx, and eng_rx follows pad_rx_in.
- R7: In digital loopback bit 5 has no effect on eng_rx or pad_rx_oe.
- R8: In analog loopback with bit 6 set, the pad_cs_out line chosen by bits 10:8 (0 to 7) is the inverse of the same eng_cs_num bit. All other lines equal eng_cs_num.
- R9: With bit 6 clear, or in digital loopback, pad_cs_out equals eng_cs_num.
- R10: In master mode (eng_master = 1), with test mode on and bit 12 set, eng_ena_in reads 1 from the cycle of the eng_shift_start strobe through the cycle of the eng_xfer_end strobe, and then returns to pad_ena_in.
- R11: In slave mode (eng_master = 0), the same window as R10 forces eng_cs_in to 1, and eng_ena_in is left alone.
- R12: A start strobe has no forcing effect when bit 12 is clear or when test mode is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Control word write strobe |
| bus_wr_data | input | 32 | Control word write data |
| bus_rd_data | output | 32 | Stored control word |
| eng_master | input | 1 | 1 = engine is master, 0 = slave |
| eng_shift_start | input | 1 | One-cycle strobe at the start of shifting |
| eng_xfer_end | input | 1 | One-cycle strobe at the end of the transfer |
| eng_cs_num | input | 8 | Chip-select levels requested by the engine |
| eng_tx | input | 1 | Serial data out of the engine |
| eng_rx | output | 1 | Serial data into the engine |
| eng_ena_in | output | 1 | Handshake level seen by the engine (master) |
| eng_cs_in | output | 1 | Incoming chip-select seen by the engine (slave) |
| pad_tx_out | output | 1 | Transmit pad drive |
| pad_tx_in | input | 1 | Transmit pad readback |
| pad_rx_in | input | 1 | Receive pad input |
| pad_rx_out | output | 1 | Receive pad drive in receive-pad loopback |
| pad_rx_oe | output | 1 | Receive pad output enable |
| pad_cs_out | output | 8 | Chip-select pad drive |
| pad_ena_in | input | 1 | Handshake pad input |
| pad_cs_in | input | 1 | Incoming chip-select pad input |

## Verification
The bench walks all sixteen key values. A decoder that tested only some key bits, or armed on any non-zero key, would loop data back when it should not. Each of the eight fault targets is inverted in turn, with neighbouring lines held at a known pattern. An off-by-one or a wrong-polarity decode would then corrupt a second line or the wrong one. The length fault is checked on the strobe cycle itself, through the end-strobe cycle, and one cycle later. A registered-only forcing would miss the first cycle, and a release placed too early or too late would show at either edge. The bench also confirms that the path bit is ignored in digital mode, and that forcing never reaches the handshake that belongs to the other role.

// File: rtl/stt_pkg.sv
package stt_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned KEY_W    = 4;
  localparam int unsigned KEY_LSB  = 0;
  localparam logic [KEY_W-1:0] ARM_KEY = 4'hA;
  localparam int unsigned TYPE_BIT = 4;
  localparam int unsigned PATH_BIT = 5;
  localparam int unsigned CSF_BIT  = 6;
  localparam int unsigned TGT_W    = 3;
  localparam int unsigned TGT_LSB  = 8;
  localparam int unsigned LEN_BIT  = 12;
  localparam int unsigned NCS      = 1 << TGT_W;

  localparam logic [REG_W-1:0] WMASK =
      (REG_W'((1 << KEY_W) - 1) << KEY_LSB) |
      (REG_W'(1) << TYPE_BIT) |
      (REG_W'(1) << PATH_BIT) |
      (REG_W'(1) << CSF_BIT)  |
      (REG_W'((1 << TGT_W) - 1) << TGT_LSB) |
      (REG_W'(1) << LEN_BIT);

  typedef enum logic [1:0] {
    LB_OFF     = 2'd0,
    LB_DIGITAL = 2'd1,
    LB_PAD_TX  = 2'd2,
    LB_PAD_RX  = 2'd3
  } lb_mode_e;
endpackage

// File: rtl/stt_ctrl_reg.sv
module stt_ctrl_reg
  import stt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output lb_mode_e         mode,
  output logic             test_on,
  output logic             csf_en,
  output logic [TGT_W-1:0] csf_tgt,
  output logic             len_fault
);
  logic [REG_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word_q <= '0;
    else if (wr_en) word_q <= wr_data & WMASK;
  end

  assign rd_data   = word_q;
  assign test_on   = (word_q[KEY_LSB +: KEY_W] == ARM_KEY);
  assign csf_en    = word_q[CSF_BIT];
  assign csf_tgt   = word_q[TGT_LSB +: TGT_W];
  assign len_fault = word_q[LEN_BIT];

  always_comb begin
    if (!test_on)               mode = LB_OFF;
    else if (!word_q[TYPE_BIT]) mode = LB_DIGITAL;
    else if (word_q[PATH_BIT])  mode = LB_PAD_RX;
    else                        mode = LB_PAD_TX;
  end

  // R1: undefined bits never read back as 1
  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~WMASK) == '0);
  // R1: a write is visible on the next cycle
  assert_write_visible_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == ($past(wr_data) & WMASK));
endmodule

// File: rtl/stt_loop_path.sv
module stt_loop_path
  import stt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  lb_mode_e mode,
  input  logic     eng_tx,
  input  logic     pad_tx_in,
  input  logic     pad_rx_in,
  output logic     eng_rx,
  output logic     pad_tx_out,
  output logic     pad_rx_out,
  output logic     pad_rx_oe
);
  assign pad_tx_out = eng_tx;

  always_comb begin
    pad_rx_out = 1'b0;
    pad_rx_oe  = 1'b0;
    unique case (mode)
      LB_DIGITAL: eng_rx = eng_tx;
      LB_PAD_TX:  eng_rx = pad_tx_in;
      LB_PAD_RX: begin
        eng_rx     = pad_rx_in;
        pad_rx_out = eng_tx;
        pad_rx_oe  = 1'b1;
      end
      default:    eng_rx = pad_rx_in;
    endcase
  end

  // R3: outside test mode the receive pad is never driven
  assert_rx_pad_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == LB_OFF) |-> (!pad_rx_oe && eng_rx == pad_rx_in));
  // R6: receive-pad loopback drives the pad with engine data
  assert_rx_pad_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == LB_PAD_RX) |-> (pad_rx_oe && pad_rx_out == eng_tx));
endmodule

// File: rtl/stt_fault_inject.sv
module stt_fault_inject
  import stt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  lb_mode_e         mode,
  input  logic             test_on,
  input  logic             csf_en,
  input  logic [TGT_W-1:0] csf_tgt,
  input  logic             len_fault,
  input  logic             eng_master,
  input  logic             eng_shift_start,
  input  logic             eng_xfer_end,
  input  logic [NCS-1:0]   eng_cs_num,
  input  logic             pad_ena_in,
  input  logic             pad_cs_in,
  output logic [NCS-1:0]   pad_cs_out,
  output logic             eng_ena_in,
  output logic             eng_cs_in
);
  logic cs_flip_on;
  assign cs_flip_on = csf_en && (mode == LB_PAD_TX || mode == LB_PAD_RX);

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    assign pad_cs_out[g] = eng_cs_num[g] ^ (cs_flip_on && csf_tgt == TGT_W'(g));
  end

  logic armed, hold_q, force_hi;
  assign armed = test_on && len_fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       hold_q <= 1'b0;
    else if (eng_shift_start && armed) hold_q <= 1'b1;
    else if (eng_xfer_end)             hold_q <= 1'b0;
  end

  assign force_hi   = hold_q || (eng_shift_start && armed);
  assign eng_ena_in = (force_hi && eng_master)  ? 1'b1 : pad_ena_in;
  assign eng_cs_in  = (force_hi && !eng_master) ? 1'b1 : pad_cs_in;

  // R8: at most one chip-select line differs from the request
  assert_one_cs_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pad_cs_out ^ eng_cs_num));
  // R9: no inversion outside analog fault mode
  assert_cs_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_flip_on |-> pad_cs_out == eng_cs_num);
  // R10: the forcing window stays open until the end strobe
  assert_hold_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (force_hi && !eng_xfer_end) |=> hold_q);
  // R12: an unarmed start never opens the window
  assert_no_arm_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_q && !armed) |=> !hold_q);
endmodule

// File: rtl/spi_selftest_ctl.sv
module spi_selftest_ctl
  import stt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr_en,
  input  logic [REG_W-1:0] bus_wr_data,
  output logic [REG_W-1:0] bus_rd_data,
  input  logic             eng_master,
  input  logic             eng_shift_start,
  input  logic             eng_xfer_end,
  input  logic [NCS-1:0]   eng_cs_num,
  input  logic             eng_tx,
  output logic             eng_rx,
  output logic             eng_ena_in,
  output logic             eng_cs_in,
  output logic             pad_tx_out,
  input  logic             pad_tx_in,
  input  logic             pad_rx_in,
  output logic             pad_rx_out,
  output logic             pad_rx_oe,
  output logic [NCS-1:0]   pad_cs_out,
  input  logic             pad_ena_in,
  input  logic             pad_cs_in
);
  lb_mode_e         mode;
  logic             test_on, csf_en, len_fault;
  logic [TGT_W-1:0] csf_tgt;

  stt_ctrl_reg i_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .wr_data(bus_wr_data),
    .rd_data(bus_rd_data), .mode(mode), .test_on(test_on),
    .csf_en(csf_en), .csf_tgt(csf_tgt), .len_fault(len_fault)
  );

  stt_loop_path i_path (
    .clk(clk), .rst_n(rst_n), .mode(mode), .eng_tx(eng_tx),
    .pad_tx_in(pad_tx_in), .pad_rx_in(pad_rx_in), .eng_rx(eng_rx),
    .pad_tx_out(pad_tx_out), .pad_rx_out(pad_rx_out), .pad_rx_oe(pad_rx_oe)
  );

  stt_fault_inject i_fault (
    .clk(clk), .rst_n(rst_n), .mode(mode), .test_on(test_on),
    .csf_en(csf_en), .csf_tgt(csf_tgt), .len_fault(len_fault),
    .eng_master(eng_master), .eng_shift_start(eng_shift_start),
    .eng_xfer_end(eng_xfer_end), .eng_cs_num(eng_cs_num),
    .pad_ena_in(pad_ena_in), .pad_cs_in(pad_cs_in),
    .pad_cs_out(pad_cs_out), .eng_ena_in(eng_ena_in), .eng_cs_in(eng_cs_in)
  );

  // R2: a non-key value leaves the engine on the receive pad
  assert_key_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_data[KEY_LSB +: KEY_W] != ARM_KEY) |-> (eng_rx == pad_rx_in));
  // R11: slave-mode forcing never touches the master handshake
  assert_slave_side_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_master |-> eng_ena_in == pad_ena_in);
endmodule

// File: tb/test_spi_selftest_ctl.sv
module test_spi_selftest_ctl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [31:0] bus_wr_data = '0, bus_rd_data;
  logic        eng_master = 1'b1, eng_shift_start = 1'b0, eng_xfer_end = 1'b0;
  logic [7:0]  eng_cs_num = 8'hFF, pad_cs_out;
  logic        eng_tx = 1'b0, eng_rx, eng_ena_in, eng_cs_in;
  logic        pad_tx_out, pad_tx_in = 1'b0, pad_rx_in = 1'b0;
  logic        pad_rx_out, pad_rx_oe, pad_ena_in = 1'b0, pad_cs_in = 1'b0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spi_selftest_ctl i_spi_selftest_ctl (.*);

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk); bus_wr_en = 1'b1; bus_wr_data = d;
    @(negedge clk); bus_wr_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset value", bus_rd_data, 32'h0);
    chk("R3 reset rx_oe", {31'b0, pad_rx_oe}, 32'h0);
  endtask

  task automatic t_register();
    wr(32'hFFFF_FFFF);
    chk("R1 reserved bits", bus_rd_data, 32'h0000_177F);
    wr(32'h0000_1234);
    chk("R1 masked write", bus_rd_data, 32'h0000_1234 & 32'h177F);
    wr(32'h0);
  endtask

  task automatic t_keys();
    eng_tx = 1'b1; pad_rx_in = 1'b0;
    for (int k = 0; k < 16; k++) begin
      wr(32'(k));
      #1 chk("R2 key gate", {31'b0, eng_rx}, {31'b0, k == 10});
    end
    wr(32'h0);
  endtask

  task automatic t_passthru();
    wr(32'h0000_1775);
    for (int v = 0; v < 4; v++) begin
      eng_tx = v[0]; pad_rx_in = v[1]; pad_ena_in = v[0]; pad_cs_in = v[1];
      eng_cs_num = 8'(8'h5A ^ v);
      #1;
      chk("R3 rx", {31'b0, eng_rx}, {31'b0, v[1]});
      chk("R3 tx", {31'b0, pad_tx_out}, {31'b0, v[0]});
      chk("R3 cs", {24'b0, pad_cs_out}, {24'b0, 8'(8'h5A ^ v)});
      chk("R3 hs", {30'b0, eng_ena_in, eng_cs_in}, {30'b0, v[0], v[1]});
      chk("R3 oe", {31'b0, pad_rx_oe}, 32'h0);
    end
    wr(32'h0);
  endtask

  task automatic t_digital();
    for (int p = 0; p < 2; p++) begin
      wr(32'h0000_000A | (p << 5));
      for (int v = 0; v < 2; v++) begin
        eng_tx = v[0]; pad_rx_in = ~v[0]; pad_tx_in = ~v[0];
        #1 chk("R4 digital", {31'b0, eng_rx}, {31'b0, v[0]});
        chk("R7 path ignored", {31'b0, pad_rx_oe}, 32'h0);
      end
    end
  endtask

  task automatic t_analog();
    wr(32'h0000_001A);
    for (int v = 0; v < 2; v++) begin
      pad_tx_in = v[0]; pad_rx_in = ~v[0]; eng_tx = ~v[0];
      #1 chk("R5 tx pad", {31'b0, eng_rx}, {31'b0, v[0]});
      chk("R5 oe", {31'b0, pad_rx_oe}, 32'h0);
    end
    wr(32'h0000_003A);
    for (int v = 0; v < 2; v++) begin
      pad_rx_in = v[0]; pad_tx_in = ~v[0]; eng_tx = v[0];
      #1 chk("R6 rx pad", {31'b0, eng_rx}, {31'b0, v[0]});
      chk("R6 drive", {30'b0, pad_rx_oe, pad_rx_out}, {30'b0, 1'b1, v[0]});
    end
  endtask

  task automatic t_csfault();
    eng_cs_num = 8'hC3;
    for (int t = 0; t < 8; t++) begin
      wr(32'h0000_005A | (t << 8));
      #1 chk("R8 cs target", {24'b0, pad_cs_out}, {24'b0, 8'hC3 ^ (8'h1 << t)});
    end
    wr(32'h0000_031A);
    #1 chk("R9 cs enable clear", {24'b0, pad_cs_out}, 32'h0000_00C3);
    wr(32'h0000_034A);
    #1 chk("R9 cs digital", {24'b0, pad_cs_out}, 32'h0000_00C3);
  endtask

  task automatic t_len(bit master, string req);
    eng_master = master; pad_ena_in = 1'b0; pad_cs_in = 1'b0;
    wr(32'h0000_100A);
    @(negedge clk); eng_shift_start = 1'b1;
    #1 chk({req, " strobe cycle"}, {30'b0, eng_ena_in, eng_cs_in}, {30'b0, master, !master});
    @(negedge clk); eng_shift_start = 1'b0;
    #1 chk({req, " held"}, {30'b0, eng_ena_in, eng_cs_in}, {30'b0, master, !master});
    repeat (3) @(negedge clk);
    eng_xfer_end = 1'b1;
    #1 chk({req, " end cycle"}, {30'b0, eng_ena_in, eng_cs_in}, {30'b0, master, !master});
    @(negedge clk); eng_xfer_end = 1'b0;
    #1 chk({req, " released"}, {30'b0, eng_ena_in, eng_cs_in}, 32'h0);
  endtask

  task automatic t_len_off();
    eng_master = 1'b1; pad_ena_in = 1'b0;
    for (int c = 0; c < 2; c++) begin
      wr(c == 0 ? 32'h0000_000A : 32'h0000_1005);
      @(negedge clk); eng_shift_start = 1'b1;
      #1 chk("R12 strobe", {31'b0, eng_ena_in}, 32'h0);
      @(negedge clk); eng_shift_start = 1'b0;
      #1 chk("R12 after", {31'b0, eng_ena_in}, 32'h0);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #1 t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1 t_reset();
    t_register();
    t_keys();
    t_passthru();
    t_digital();
    t_analog();
    t_csfault();
    t_len(1'b1, "R10 master");
    t_len(1'b0, "R11 slave");
    t_len_off();
    finish_run();
  end
endmodule